// File: doc/BRIEF.md
# Filtered Two-Wire Bus Condition Detector

This block watches the clock and data lines of a two-wire serial bus (I2C) using a fast system clock. Both raw lines pass through a two-flop synchroniser and a glitch filter. The filter moves its output to a new level only after the input has held that level for `FILT_CYCLES` system clocks in a row, so any pulse narrower than that window is lost. The filtered levels then go to an edge classifier. It reports four kinds of event to a downstream protocol engine, each as a one-cycle pulse: a start condition, a stop condition, a clock rising edge together with the data bit sampled at that edge, and a clock falling edge.

A start or stop is only accepted when the data edge arrives after the filtered clock has been high for at least `GUARD_CYCLES` system clocks. Data edges that come too soon after the clock rose, in the same cycle as a clock edge, or while the clock is low give no start or stop. This keeps a data line that settles slowly around a clock transition from creating spurious conditions. The block never drives the bus and does not assemble bytes.

Top module: `bus_cond_detect`

## Requirements
- R1: A filtered line changes level only after its raw input has held the new level for `FILT_CYCLES` consecutive system clocks. A pulse of `FILT_CYCLES`-1 clocks on either line produces no event, and a pulse of exactly `FILT_CYCLES` clocks passes.
- R2: While `rst_n` is low, and after it is released with both lines idle high, every event output and `bit_o` stay 0. Both filtered lines start out high.
- R3: A clock rising edge that stays stable raises `scl_rise_o` for one cycle, exactly 3+`FILT_CYCLES` clocks after the raw change, and `bit_o` then carries the filtered data level.
- R4: A clock falling edge that stays stable raises `scl_fall_o` for one cycle, exactly 3+`FILT_CYCLES` clocks after the raw change.
- R5: A filtered data fall that arrives when the filtered clock has been high for at least `GUARD_CYCLES` clocks raises `start_o` for one cycle, 3+`FILT_CYCLES` clocks after the raw data edge.
- R6: A filtered data rise under the same clock-high condition raises `stop_o` for one cycle.
- R7: A data edge that arrives fewer than `GUARD_CYCLES` clocks after the clock rose, in the same cycle as a clock edge, or while the clock is low, produces neither `start_o` nor `stop_o`.
- R8: Every event is a one-cycle pulse. At most one of `start_o`, `stop_o`, `scl_rise_o`, `scl_fall_o` is high in any cycle, and a start or stop is never asserted in two cycles back to back.
- R9: `bit_o` changes only together with `scl_rise_o` and otherwise holds the last sampled bit. A byte sent most significant bit first comes out as the same bit sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw bus clock line |
| sda_in | input | 1 | Raw bus data line |
| start_o | output | 1 | One-cycle pulse: start condition accepted |
| stop_o | output | 1 | One-cycle pulse: stop condition accepted |
| scl_rise_o | output | 1 | One-cycle pulse: filtered clock rose |
| scl_fall_o | output | 1 | One-cycle pulse: filtered clock fell |
| bit_o | output | 1 | Data level sampled at the latest clock rise |

## Verification
The bench targets the edges of the filter window. A pulse one clock shorter than the window must vanish, and a pulse exactly the window's length must get through. A filter that is off by one either lets noise through or swallows legal edges. It also places a data edge `GUARD_CYCLES`-1 and then exactly `GUARD_CYCLES` clocks after a clock rise, and once in the same cycle. A wrong guard compare either reports a false start in the middle of a bit or misses a real one. Event latency is measured against 3+`FILT_CYCLES`, and a byte is shifted through to catch bit order or a sample taken on the wrong edge.

// File: rtl/bcd_pkg.sv
package bcd_pkg;

  // Depth of the metastability synchroniser on each raw line
  localparam int SYNC_DEPTH = 2;

  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
  } bcd_evt_t;

  // Number of events raised in one cycle
  function automatic logic [2:0] bcd_evt_count(bcd_evt_t e);
    return {2'b00, e.start} + {2'b00, e.stop} + {2'b00, e.rise} + {2'b00, e.fall};
  endfunction

  // Guard reached: saturating clock-high counter at its limit
  function automatic logic bcd_guard_met(int unsigned cnt, int unsigned guard);
    return cnt >= guard;
  endfunction

endpackage

// File: rtl/bcd_sync.sv
module bcd_sync #(
  parameter int  STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= RESET_VAL;
          else        chain[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= RESET_VAL;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];

endmodule

// File: rtl/bcd_glitch_filter.sv
module bcd_glitch_filter #(
  parameter int CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] run_cnt;
  logic          differs;
  logic          accept;

  assign differs = (d_i != q_o);
  assign accept  = differs && (run_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_o     <= 1'b1;
      run_cnt <= '0;
    end else if (!differs) begin
      run_cnt <= '0;
    end else if (accept) begin
      q_o     <= d_i;
      run_cnt <= '0;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/bcd_classify.sv
module bcd_classify
  import bcd_pkg::*;
#(
  parameter int GUARD_CYCLES = 3
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scl_f,
  input  logic     sda_f,
  output bcd_evt_t evt_o,
  output logic     bit_o
);

  localparam int GW = $clog2(GUARD_CYCLES + 1);
  localparam logic [GW-1:0] GMAX = GW'(GUARD_CYCLES);

  logic          scl_q, sda_q;
  logic [GW-1:0] hi_cnt;

  logic     scl_up, scl_dn, sda_up, sda_dn;
  logic     scl_steady;
  bcd_evt_t evt_d;

  assign scl_up     = scl_f & ~scl_q;
  assign scl_dn     = ~scl_f & scl_q;
  assign sda_up     = sda_f & ~sda_q;
  assign sda_dn     = ~sda_f & sda_q;
  assign scl_steady = scl_f & scl_q & bcd_guard_met(int'(hi_cnt), GUARD_CYCLES);

  always_comb begin
    evt_d       = '0;
    evt_d.rise  = scl_up;
    evt_d.fall  = scl_dn;
    evt_d.start = scl_steady & sda_dn;
    evt_d.stop  = scl_steady & sda_up;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      hi_cnt <= '0;
      evt_o  <= '0;
      bit_o  <= 1'b0;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
      if (!scl_f)             hi_cnt <= '0;
      else if (hi_cnt != GMAX) hi_cnt <= hi_cnt + 1'b1;
      evt_o <= evt_d;
      if (scl_up) bit_o <= sda_f;
    end
  end

endmodule

// File: rtl/bus_cond_detect.sv
module bus_cond_detect
  import bcd_pkg::*;
#(
  parameter int FILT_CYCLES  = 4,
  parameter int GUARD_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic bit_o
);

  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_lines;
  logic [NLINES-1:0] sync_lines;
  logic [NLINES-1:0] filt_lines;

  assign raw_lines = {sda_in, scl_in};

  generate
    for (genvar l = 0; l < NLINES; l++) begin : g_line
      bcd_sync #(.STAGES(SYNC_DEPTH), .RESET_VAL(1'b1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (raw_lines[l]),
        .q_o  (sync_lines[l])
      );
      bcd_glitch_filter #(.CYCLES(FILT_CYCLES)) u_filt (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (sync_lines[l]),
        .q_o  (filt_lines[l])
      );
    end
  endgenerate

  // Filtered levels, named for the checker
  logic scl_filt, sda_filt;
  assign scl_filt = filt_lines[0];
  assign sda_filt = filt_lines[1];

  bcd_evt_t evt;

  bcd_classify #(.GUARD_CYCLES(GUARD_CYCLES)) u_cls (
    .clk  (clk),
    .rst_n(rst_n),
    .scl_f(scl_filt),
    .sda_f(sda_filt),
    .evt_o(evt),
    .bit_o(bit_o)
  );

  assign start_o    = evt.start;
  assign stop_o     = evt.stop;
  assign scl_rise_o = evt.rise;
  assign scl_fall_o = evt.fall;

endmodule

// File: rtl/bcd_checker.sv
module bcd_checker
  import bcd_pkg::*;
#(
  parameter int FILT_CYCLES  = 4,
  parameter int GUARD_CYCLES = 3
) (
  input logic clk,
  input logic rst_n,
  input logic scl_in,
  input logic sda_in,
  input logic scl_filt,
  input logic sda_filt,
  input logic start_o,
  input logic stop_o,
  input logic scl_rise_o,
  input logic scl_fall_o,
  input logic bit_o
);

  localparam int RUN_CAP = FILT_CYCLES + 4;

  logic scl_last, sda_last;
  int   scl_run, sda_run, hi_len;
  bcd_evt_t ev;

  assign ev = '{start: start_o, stop: stop_o, rise: scl_rise_o, fall: scl_fall_o};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_last <= 1'b1;
      sda_last <= 1'b1;
      scl_run  <= 0;
      sda_run  <= 0;
      hi_len   <= 0;
    end else begin
      scl_last <= scl_in;
      sda_last <= sda_in;
      if (scl_in != scl_last) scl_run <= 0;
      else if (scl_run < RUN_CAP) scl_run <= scl_run + 1;
      if (sda_in != sda_last) sda_run <= 0;
      else if (sda_run < RUN_CAP) sda_run <= sda_run + 1;
      if (!scl_filt) hi_len <= 0;
      else if (hi_len < GUARD_CYCLES) hi_len <= hi_len + 1;
    end
  end

  // R1
  scl_filter_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_filt != $past(scl_filt)) |-> ($past(scl_run, 2) >= FILT_CYCLES - 1 && $past(scl_last, 2) == scl_filt));

  // R1
  sda_filter_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_filt != $past(sda_filt)) |-> ($past(sda_run, 2) >= FILT_CYCLES - 1 && $past(sda_last, 2) == sda_filt));

  // R8
  one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bcd_evt_count(ev) <= 3'd1);

  // R8
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);

  // R8
  stop_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |=> !stop_o);

  // R5
  start_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> ($past(scl_filt) && !$past(sda_filt)));

  // R6
  stop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |-> ($past(scl_filt) && $past(sda_filt)));

  // R7
  guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o || stop_o) |-> ($past(hi_len) >= GUARD_CYCLES));

  // R3
  rise_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise_o |-> ($past(scl_filt) && bit_o == $past(sda_filt)));

  // R4
  fall_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_fall_o |-> !$past(scl_filt));

  // R9
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !scl_rise_o |-> $stable(bit_o));

endmodule

bind bus_cond_detect bcd_checker #(
  .FILT_CYCLES (FILT_CYCLES),
  .GUARD_CYCLES(GUARD_CYCLES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_in    (scl_in),
  .sda_in    (sda_in),
  .scl_filt  (scl_filt),
  .sda_filt  (sda_filt),
  .start_o   (start_o),
  .stop_o    (stop_o),
  .scl_rise_o(scl_rise_o),
  .scl_fall_o(scl_fall_o),
  .bit_o     (bit_o)
);

// File: tb/bus_cond_detect_test.sv
module bus_cond_detect_test;

  localparam int CLK_PERIOD = 10;
  localparam int FILT       = 4;
  localparam int GUARD      = 3;
  localparam int LAT        = 3 + FILT;
  localparam int HOLD       = LAT + GUARD + 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda = 1'b1;
  logic start_o, stop_o, scl_rise_o, scl_fall_o, bit_o;

  int n_checks = 0;
  int n_err    = 0;
  int n_start = 0, n_stop = 0, n_rise = 0, n_fall = 0, viol = 0;
  logic [7:0] bits = '0;
  logic p_start = 1'b0, p_stop = 1'b0;
  bit   done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bus_cond_detect #(.FILT_CYCLES(FILT), .GUARD_CYCLES(GUARD)) uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda),
    .start_o(start_o), .stop_o(stop_o), .scl_rise_o(scl_rise_o),
    .scl_fall_o(scl_fall_o), .bit_o(bit_o)
  );

  // Event monitor, sampling away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (start_o)    n_start++;
      if (stop_o)     n_stop++;
      if (scl_fall_o) n_fall++;
      if (scl_rise_o) begin
        n_rise++;
        bits = {bits[6:0], bit_o};
      end
      if (int'(start_o) + int'(stop_o) + int'(scl_rise_o) + int'(scl_fall_o) > 1) viol++;
      if ((start_o && p_start) || (stop_o && p_stop)) viol++;
      p_start = start_o;
      p_stop  = stop_o;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr();
    n_start = 0; n_stop = 0; n_rise = 0; n_fall = 0;
  endtask

  // which: 0 rise, 1 fall, 2 start
  task automatic measure(input int which, output int cycles);
    cycles = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      cycles++;
      if ((which == 0 && scl_rise_o) || (which == 1 && scl_fall_o) || (which == 2 && start_o)) break;
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; scl = 1'b1; sda = 1'b1;
    wait_n(5);
    check("R2", "events during reset", int'(start_o | stop_o | scl_rise_o | scl_fall_o), 0);
    check("R2", "bit_o during reset", int'(bit_o), 0);
    rst_n = 1'b1;
    wait_n(HOLD * 2);
    check("R2", "events after release", n_start + n_stop + n_rise + n_fall, 0);
    check("R2", "bit_o after release", int'(bit_o), 0);
  endtask

  task automatic t_start();
    int c;
    clr();
    sda = 1'b0;
    measure(2, c);
    check("R5", "start latency", c, LAT);
    wait_n(HOLD);
    check("R5", "start count", n_start, 1);
    check("R5", "no stray stop/edges", n_stop + n_rise + n_fall, 0);
  endtask

  task automatic send_bit(input logic b);
    scl = 1'b0; wait_n(HOLD);
    sda = b;    wait_n(HOLD);
    scl = 1'b1; wait_n(HOLD);
  endtask

  task automatic t_byte(input logic [7:0] v);
    clr();
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    scl = 1'b0; wait_n(HOLD);
    check("R9", "byte bits", int'(bits), int'(v));
    check("R3", "rise count", n_rise, 8);
    check("R4", "fall count", n_fall, 9);
    check("R7", "no start/stop on low-clock data", n_start + n_stop, 0);
    check("R9", "bit_o holds last bit", int'(bit_o), int'(v[0]));
  endtask

  task automatic t_stop();
    scl = 1'b0; wait_n(HOLD);
    sda = 1'b0; wait_n(HOLD);
    clr();
    scl = 1'b1; wait_n(HOLD);
    sda = 1'b1; wait_n(HOLD);
    check("R6", "stop count", n_stop, 1);
    check("R6", "no start", n_start, 0);
    check("R3", "rise before stop", n_rise, 1);
  endtask

  task automatic t_latency();
    int c;
    scl = 1'b0; wait_n(HOLD);
    clr();
    scl = 1'b1;
    measure(0, c);
    check("R3", "rise latency", c, LAT);
    check("R3", "bit_o sampled high", int'(bit_o), 1);
    wait_n(HOLD);
    scl = 1'b0;
    measure(1, c);
    check("R4", "fall latency", c, LAT);
    wait_n(HOLD);
    scl = 1'b1; wait_n(HOLD);
  endtask

  task automatic t_glitch();
    // clock glitches, data low so no conditions
    scl = 1'b0; wait_n(HOLD);
    sda = 1'b0; wait_n(HOLD);
    clr();
    scl = 1'b1; wait_n(FILT - 1); scl = 1'b0; wait_n(HOLD);
    check("R1", "short scl pulse edges", n_rise + n_fall, 0);
    scl = 1'b1; wait_n(FILT); scl = 1'b0; wait_n(HOLD);
    check("R1", "window scl pulse rise", n_rise, 1);
    check("R1", "window scl pulse fall", n_fall, 1);
    // data glitches with the clock high
    sda = 1'b1; wait_n(HOLD);
    scl = 1'b1; wait_n(HOLD);
    clr();
    sda = 1'b0; wait_n(FILT - 1); sda = 1'b1; wait_n(HOLD);
    check("R1", "short sda pulse conditions", n_start + n_stop, 0);
    sda = 1'b0; wait_n(FILT); sda = 1'b1; wait_n(HOLD);
    check("R1", "window sda pulse start", n_start, 1);
    check("R1", "window sda pulse stop", n_stop, 1);
  endtask

  task automatic t_guard();
    // data fall one clock short of the guard
    scl = 1'b0; wait_n(HOLD);
    clr();
    scl = 1'b1; wait_n(GUARD - 1); sda = 1'b0; wait_n(HOLD);
    check("R7", "early fall no start", n_start, 0);
    check("R7", "early fall rise seen", n_rise, 1);
    scl = 1'b0; wait_n(HOLD); sda = 1'b1; wait_n(HOLD);
    // exactly at the guard
    clr();
    scl = 1'b1; wait_n(GUARD); sda = 1'b0; wait_n(HOLD);
    check("R5", "fall at guard gives start", n_start, 1);
    // stop side one clock short
    scl = 1'b0; wait_n(HOLD);
    clr();
    scl = 1'b1; wait_n(GUARD - 1); sda = 1'b1; wait_n(HOLD);
    check("R7", "early rise no stop", n_stop, 0);
    // same-cycle data and clock edge
    scl = 1'b0; wait_n(HOLD);
    clr();
    scl = 1'b1; sda = 1'b0; wait_n(HOLD);
    check("R7", "coincident edge no start", n_start, 0);
    check("R7", "coincident edge rise", n_rise, 1);
    sda = 1'b1; wait_n(HOLD);
  endtask

  initial begin
    t_reset();
    t_start();
    t_byte(8'hA5);
    t_stop();
    t_latency();
    t_glitch();
    t_guard();
    t_start();
    t_byte(8'h3C);
    t_stop();
    check("R8", "multi-event or repeated pulse cycles", viol, 0);
    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
      $finish;
    end
  end

endmodule